// File: doc/BRIEF.md
# Channel Input Port Selector and Sample Qualifier

This block sits at the front of a receive channel. Two input ports feed it. Each port carries a 14-bit mantissa, a 3-bit exponent and an enable line. A select bit picks one port. The enable line of the chosen port then decides which clock cycles carry a real sample for the channel.

A 2-bit rate mode sets how the enable is read:
- **Masked full rate:** every clock cycle is a sample, and the data is forced to zero while the enable is low.
- **Level-gated:** the enable marks samples cycle by cycle.
- **Edge-marked:** only the cycle after a low-to-high change of the enable carries a sample.

The block registers the chosen mantissa and exponent once on the high-speed clock and adds a one-cycle valid strobe. Downstream logic takes the data on each cycle where the strobe is high.

Top module: `chin_input_qual`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and both `out_mant` and `out_expo` are 0.
- R2: When `port_b_sel` is 0, port A's mantissa, exponent and enable are used. When it is 1, port B's mantissa, exponent and enable are used. The other port has no effect on the outputs.
- R3: In rate mode 2'b00, `out_valid` is high on every cycle after reset. A cycle whose selected enable is low yields mantissa 0 and exponent 0.
- R4: In rate mode 2'b01, `out_valid` follows the selected enable sampled at the previous clock edge. An enable that toggles every cycle gives exactly one strobe per two cycles.
- R5: In rate mode 2'b10, a strobe is produced when the selected enable is sampled high at an edge after being sampled low at the edge before. An enable held high for many cycles gives one strobe only.
- R6: Rate mode 2'b11 behaves exactly like rate mode 2'b10.
- R7: In the edge modes, an enable that is already high when reset is released does not count as a low-to-high change.
- R8: While `out_valid` is low, `out_mant` and `out_expo` keep the value they last took.
- R9: The data and strobe produced from the inputs sampled at a clock edge appear on the outputs right after that same edge: one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| port_b_sel | input | 1 | 0 selects port A, 1 selects port B |
| rate_mode | input | 2 | Rate mode: 00 masked, 01 level, 10/11 edge |
| a_mant | input | 14 | Port A mantissa |
| a_expo | input | 3 | Port A exponent |
| a_en | input | 1 | Port A enable |
| b_mant | input | 14 | Port B mantissa |
| b_expo | input | 3 | Port B exponent |
| b_en | input | 1 | Port B enable |
| out_mant | output | 14 | Registered mantissa of the selected port |
| out_expo | output | 3 | Registered exponent of the selected port |
| out_valid | output | 1 | One-cycle sample strobe |

## Verification
The assertions assume that `port_b_sel`, `rate_mode` and both enables are synchronous to `clk` and hold stable around each rising edge. They also assume that reset is asserted from time zero. The bench meets these assumptions by changing every input only on the falling edge and by holding reset through the first cycles. The properties for the edge modes only rely on the fact that a low enable can never produce a strobe. Because of that, switching ports in the middle of a run stays within what they claim.

// File: rtl/chin_pkg.sv
package chin_pkg;
    parameter int MANT_W = 14;
    parameter int EXPO_W = 3;
    localparam int SAMP_W = MANT_W + EXPO_W;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXPO_W-1:0] expo;
    } samp_t;

    typedef enum logic [1:0] {
        RATE_MASKED   = 2'b00,
        RATE_LEVEL    = 2'b01,
        RATE_EDGE     = 2'b10,
        RATE_EDGE_ALT = 2'b11
    } rate_e;

    localparam samp_t SAMP_ZERO = '0;

    // Both upper encodings share the edge-marked behaviour.
    function automatic logic is_edge_mode(rate_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/chin_port_mux.sv
module chin_port_mux
    import chin_pkg::*;
(
    input  logic  sel_b,
    input  samp_t a_samp,
    input  logic  a_en,
    input  samp_t b_samp,
    input  logic  b_en,
    output samp_t sel_samp,
    output logic  sel_en
);
    always_comb begin
        if (sel_b) begin
            sel_samp = b_samp;
            sel_en   = b_en;
        end else begin
            sel_samp = a_samp;
            sel_en   = a_en;
        end
    end
endmodule

// File: rtl/chin_rate_qual.sv
module chin_rate_qual
    import chin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_e mode,
    input  logic  en,
    output logic  take,
    output logic  zero_data
);
    // Enable level seen at the previous edge; reset high so that a
    // level already high out of reset is not taken as a rise.
    logic en_prev_q;

    always_ff @(posedge clk) begin
        if (rst) en_prev_q <= 1'b1;
        else     en_prev_q <= en;
    end

    always_comb begin
        take      = 1'b0;
        zero_data = 1'b0;
        if (is_edge_mode(mode)) begin
            take = en & ~en_prev_q;
        end else if (mode == RATE_LEVEL) begin
            take = en;
        end else begin
            take      = 1'b1;
            zero_data = ~en;
        end
    end
endmodule

// File: rtl/chin_out_reg.sv
module chin_out_reg
    import chin_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  zero_data,
    input  samp_t din,
    output samp_t dout,
    output logic  valid
);
    samp_t data_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= SAMP_ZERO;
            valid_q <= 1'b0;
        end else begin
            valid_q <= take;
            if (take) data_q <= zero_data ? SAMP_ZERO : din;
        end
    end

    assign dout  = data_q;
    assign valid = valid_q;
endmodule

// File: rtl/chin_input_qual.sv
module chin_input_qual
    import chin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              port_b_sel,
    input  logic [1:0]        rate_mode,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [EXPO_W-1:0] a_expo,
    input  logic              a_en,
    input  logic [MANT_W-1:0] b_mant,
    input  logic [EXPO_W-1:0] b_expo,
    input  logic              b_en,
    output logic [MANT_W-1:0] out_mant,
    output logic [EXPO_W-1:0] out_expo,
    output logic              out_valid
);
    samp_t a_samp, b_samp, sel_samp, out_samp;
    logic  sel_en, take, zero_data;

    assign a_samp = '{mant: a_mant, expo: a_expo};
    assign b_samp = '{mant: b_mant, expo: b_expo};

    chin_port_mux u_mux (
        .sel_b    (port_b_sel),
        .a_samp   (a_samp),
        .a_en     (a_en),
        .b_samp   (b_samp),
        .b_en     (b_en),
        .sel_samp (sel_samp),
        .sel_en   (sel_en)
    );

    chin_rate_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .mode      (rate_e'(rate_mode)),
        .en        (sel_en),
        .take      (take),
        .zero_data (zero_data)
    );

    chin_out_reg u_oreg (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .zero_data (zero_data),
        .din       (sel_samp),
        .dout      (out_samp),
        .valid     (out_valid)
    );

    assign out_mant = out_samp.mant;
    assign out_expo = out_samp.expo;
endmodule

// File: rtl/chin_input_qual_chk.sv
module chin_input_qual_chk
    import chin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              port_b_sel,
    input logic [1:0]        rate_mode,
    input logic              a_en,
    input logic              b_en,
    input logic [MANT_W-1:0] out_mant,
    input logic [EXPO_W-1:0] out_expo,
    input logic              out_valid
);
    logic en_sel;
    assign en_sel = port_b_sel ? b_en : a_en;

    // R3: masked mode strobes on every cycle
    a_r3_full_rate: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'b00) |=> out_valid);

    // R3: masked mode zeroes data when the enable is low
    a_r3_zero_mask: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'b00 && !en_sel) |=> (out_valid && out_mant == '0 && out_expo == '0));

    // R4: level mode strobe follows the enable
    a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'b01) |=> (out_valid == $past(en_sel)));

    // R5 / R6: edge modes never strobe on a low enable
    a_r5_edge_low_quiet: assert property (@(posedge clk) disable iff (rst)
        (rate_mode[1] && !en_sel) |=> !out_valid);

    // R8: data holds while no strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_mant) && $stable(out_expo)));

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_mant == '0 && out_expo == '0));
endmodule

bind chin_input_qual chin_input_qual_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_b_sel (port_b_sel),
    .rate_mode  (rate_mode),
    .a_en       (a_en),
    .b_en       (b_en),
    .out_mant   (out_mant),
    .out_expo   (out_expo),
    .out_valid  (out_valid)
);

// File: tb/tb_chin_input_qual.sv
`timescale 1ns/1ps
module tb_chin_input_qual;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_b_sel = 1'b0;
    logic [1:0]  rate_mode = 2'b00;
    logic [13:0] a_mant = '0, b_mant = '0;
    logic [2:0]  a_expo = '0, b_expo = '0;
    logic        a_en = 1'b0, b_en = 1'b0;
    logic [13:0] out_mant;
    logic [2:0]  out_expo;
    logic        out_valid;

    always #2 clk = ~clk; // 250 MHz

    chin_input_qual dut (
        .clk(clk), .rst(rst), .port_b_sel(port_b_sel), .rate_mode(rate_mode),
        .a_mant(a_mant), .a_expo(a_expo), .a_en(a_en),
        .b_mant(b_mant), .b_expo(b_expo), .b_en(b_en),
        .out_mant(out_mant), .out_expo(out_expo), .out_valid(out_valid)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string req     = "R1";

    // behavioural reference state
    int m_mant = 0, m_expo = 0, m_valid = 0, m_prev = 1;
    int strobes = 0;

    task automatic model_edge();
        int en, mant, expo;
        en   = port_b_sel ? int'(b_en)   : int'(a_en);
        mant = port_b_sel ? int'(b_mant) : int'(a_mant);
        expo = port_b_sel ? int'(b_expo) : int'(a_expo);
        if (rst) begin
            m_mant = 0; m_expo = 0; m_valid = 0; m_prev = 1;
        end else begin
            if (rate_mode == 2'b00) begin
                m_valid = 1;
                m_mant  = en ? mant : 0;
                m_expo  = en ? expo : 0;
            end else if (rate_mode == 2'b01) begin
                m_valid = en;
                if (en != 0) begin m_mant = mant; m_expo = expo; end
            end else begin
                m_valid = (en == 1 && m_prev == 0) ? 1 : 0;
                if (m_valid != 0) begin m_mant = mant; m_expo = expo; end
            end
            m_prev = en;
        end
    endtask

    // one clock: model at the rising edge, compare at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_tests++;
        if (int'(out_valid) != m_valid || int'(out_mant) != m_mant || int'(out_expo) != m_expo) begin
            n_fail++;
            $display("FAIL %s: got valid=%0d mant=%0d expo=%0d, expected valid=%0d mant=%0d expo=%0d",
                     req, out_valid, out_mant, out_expo, m_valid, m_mant, m_expo);
        end
        if (out_valid) strobes++;
    endtask

    task automatic rand_data();
        a_mant = 14'($urandom); a_expo = 3'($urandom);
        b_mant = 14'($urandom); b_expo = 3'($urandom);
    endtask

    task automatic count_check(string r, int got, int want);
        n_tests++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: strobe count %0d, expected %0d", r, got, want);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        req = "R1";
        for (int i = 0; i < 4; i++) begin rand_data(); a_en = 1'b1; step(); end
        rst = 1'b0; a_en = 1'b0;
        step();

        // R3: masked full rate on port A, random enable
        req = "R3"; rate_mode = 2'b00;
        for (int i = 0; i < 40; i++) begin rand_data(); a_en = 1'($urandom); b_en = 1'($urandom); step(); end

        // R2: port B selected, port A toggles freely
        req = "R2"; port_b_sel = 1'b1;
        for (int i = 0; i < 40; i++) begin rand_data(); a_en = 1'($urandom); b_en = 1'($urandom); step(); end
        rate_mode = 2'b01;
        for (int i = 0; i < 30; i++) begin rand_data(); a_en = 1'($urandom); b_en = 1'($urandom); step(); end
        port_b_sel = 1'b0;

        // R4: level mode, toggling enable gives half rate
        req = "R4"; rate_mode = 2'b01; a_en = 1'b0;
        step();
        strobes = 0;
        for (int i = 0; i < 20; i++) begin rand_data(); a_en = ~a_en; step(); end
        count_check("R4", strobes, 10);

        // R8: hold while enable stays low in level mode
        req = "R8";
        for (int i = 0; i < 30; i++) begin rand_data(); a_en = ($urandom % 4 == 0); step(); end

        // R5: edge mode, held-high enable gives one strobe
        req = "R5"; rate_mode = 2'b10; a_en = 1'b0;
        step();
        strobes = 0;
        a_en = 1'b1;
        for (int i = 0; i < 12; i++) begin rand_data(); step(); end
        count_check("R5", strobes, 1);
        for (int i = 0; i < 40; i++) begin rand_data(); a_en = 1'($urandom); step(); end

        // R6: reserved encoding behaves as edge mode
        req = "R6"; rate_mode = 2'b11; a_en = 1'b0;
        step();
        strobes = 0;
        a_en = 1'b1;
        for (int i = 0; i < 8; i++) begin rand_data(); step(); end
        count_check("R6", strobes, 1);
        for (int i = 0; i < 40; i++) begin rand_data(); a_en = 1'($urandom); step(); end

        // R7: enable high across reset release is no rise
        req = "R7"; rate_mode = 2'b10; a_en = 1'b1; rst = 1'b1;
        step(); step();
        rst = 1'b0;
        strobes = 0;
        for (int i = 0; i < 6; i++) begin rand_data(); step(); end
        count_check("R7", strobes, 0);

        // R9: single-register latency in masked mode
        req = "R9"; rate_mode = 2'b00;
        for (int i = 0; i < 10; i++) begin rand_data(); a_en = 1'b1; step(); end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule